// File: doc/BRIEF.md
# Shift-Amount Barrel Switch

This block takes a 32-bit word, typically the result of an adder, and passes it through a barrel switch controlled by a 5-bit shift-amount register. A 2-bit mode picks one of four behaviours. The word can pass unchanged, shift right logically by the stored amount, or shift left logically by the complement of that amount relative to the word width. The fourth mode combines the two shifts into a rotate right by the stored amount. The switch path is purely combinational.

The shift-amount register is the only clocked state. A 2-bit operation code either keeps it or replaces it with its complement relative to 32. A third code reloads it from the switch's own output in the same cycle, using a fixed bit remap. This lets an amount computed by the data path be moved into the register in one step. Decoding of the controlling instruction and loading the amount from a literal are done elsewhere.

Top module: `shamt_barrel`

## Requirements
- R1: After reset the stored amount (`amt_out`) is 0.
- R2: With `mode` = 0, `data_out` equals `data_in`.
- R3: With `mode` = 1, `data_out` is `data_in` shifted right logically by the stored amount, with zeros entering at the top.
- R4: With `mode` = 2, `data_out` is `data_in` shifted left logically by (32 − stored amount). When the stored amount is 0, the output is all zeros.
- R5: With `mode` = 3, `data_out` is `data_in` rotated right by the stored amount, so output bit i is input bit (i + amount) mod 32. When the amount is 0, the output equals the input.
- R6: An `amt_op` of 0 or 3 leaves the stored amount unchanged at the next clock edge.
- R7: An `amt_op` of 1 replaces the stored amount with (32 − amount) truncated to 5 bits, so an amount of 0 stays 0.
- R8: An `amt_op` of 2 loads the stored amount at the next edge from the current `data_out`. New bits [1:0] take `data_out[1:0]`, and new bits [4:2] take `data_out[5:3]`.
- R9: `data_out` follows the inputs and the stored amount in the same cycle. A change of the stored amount takes effect on `data_out` only after the clock edge that writes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_in | input | 32 | Word entering the switch |
| mode | input | 2 | Switch behaviour: 0 pass, 1 right, 2 left by complement, 3 rotate |
| amt_op | input | 2 | Amount register operation: 0 keep, 1 complement, 2 load from output, 3 keep |
| data_out | output | 32 | Switch result |
| amt_out | output | 5 | Current stored shift amount |

## Verification
The hard part is placing every one of the 32 shift amounts in the register. From the ports, an amount can only come from the complement operation or from reloading through the switch output. The stimulus sets up each amount with a reload in pass mode. It builds the input word so that its bits [5:3] and [1:0] spell the target amount. It then drives all four modes with several data patterns at that amount. Reloads through a shifted output and complement round trips, including the zero amount, test the feedback path under conditions other than pass-through.

// File: rtl/shamt_barrel_pkg.sv
package shamt_barrel_pkg;

    typedef enum logic [1:0] {
        BS_PASS    = 2'd0,
        BS_SHR     = 2'd1,
        BS_SHL_CPL = 2'd2,
        BS_ROR     = 2'd3
    } bs_mode_e;

    typedef enum logic [1:0] {
        AMT_KEEP     = 2'd0,
        AMT_NEGATE   = 2'd1,
        AMT_LOAD     = 2'd2,
        AMT_KEEP_ALT = 2'd3
    } amt_op_e;

endpackage

// File: rtl/bs_shift_core.sv
module bs_shift_core
    import shamt_barrel_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [1:0]       mode,
    input  logic [AMT_W-1:0] amt,
    output logic [WIDTH-1:0] dout
);

    logic [AMT_W:0]   left_amt;
    logic [WIDTH-1:0] shr_v;
    logic [WIDTH-1:0] shl_v;

    always_comb begin
        // complement amount: WIDTH when amt==0, which shifts everything out
        left_amt = (AMT_W+1)'(WIDTH) - {1'b0, amt};
        shr_v    = din >> amt;
        shl_v    = din << left_amt;
        unique case (bs_mode_e'(mode))
            BS_PASS:    dout = din;
            BS_SHR:     dout = shr_v;
            BS_SHL_CPL: dout = shl_v;
            BS_ROR:     dout = shl_v ^ shr_v;
            default:    dout = din;
        endcase
    end

endmodule

// File: rtl/bs_amt_reg.sv
module bs_amt_reg
    import shamt_barrel_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] fb,
    output logic [AMT_W-1:0] amt_q
);

    typedef struct packed {
        logic [AMT_W-1:0] amt;
    } amt_state_t;

    amt_state_t       st_d, st_q;
    logic [AMT_W:0]   neg_w;
    logic [WIDTH-1:0] remap_w;

    always_comb begin
        neg_w   = (AMT_W+1)'(WIDTH) - {1'b0, st_q.amt};
        remap_w = ((fb >> 1) & ~WIDTH'(3)) ^ (fb & WIDTH'(3));
        st_d    = st_q;
        unique case (amt_op_e'(op))
            AMT_KEEP:     st_d.amt = st_q.amt;
            AMT_NEGATE:   st_d.amt = neg_w[AMT_W-1:0];
            AMT_LOAD:     st_d.amt = remap_w[AMT_W-1:0];
            AMT_KEEP_ALT: st_d.amt = st_q.amt;
            default:      st_d.amt = st_q.amt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign amt_q = st_q.amt;

    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd0 || op == 2'd3) |=> amt_q == $past(amt_q));

    p_negate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'd1 |=> AMT_W'(amt_q + $past(amt_q)) == '0);

    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'd2 |=> amt_q == {$past(fb[AMT_W:3]), $past(fb[1:0])});

endmodule

// File: rtl/shamt_barrel.sv
module shamt_barrel
    import shamt_barrel_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] data_in,
    input  logic [1:0]       mode,
    input  logic [1:0]       amt_op,
    output logic [WIDTH-1:0] data_out,
    output logic [AMT_W-1:0] amt_out
);

    logic [AMT_W-1:0] amt_w;
    logic [WIDTH-1:0] sw_out_w;

    bs_shift_core #(.WIDTH(WIDTH)) u_core (
        .din  (data_in),
        .mode (mode),
        .amt  (amt_w),
        .dout (sw_out_w)
    );

    bs_amt_reg #(.WIDTH(WIDTH)) u_amt (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (amt_op),
        .fb    (sw_out_w),
        .amt_q (amt_w)
    );

    assign data_out = sw_out_w;
    assign amt_out  = amt_w;

    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'd0 |-> data_out == data_in);

    p_left_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && amt_out == '0) |-> data_out == '0);

    p_ror_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && amt_out == '0) |-> data_out == data_in);

    p_right_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && amt_out != '0) |-> data_out[WIDTH-1] == 1'b0);

endmodule

// File: tb/shamt_barrel_bench.sv
`timescale 1ns/1ps
module shamt_barrel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] data_in = '0;
    logic [1:0]  mode = '0;
    logic [1:0]  amt_op = '0;
    logic [31:0] data_out;
    logic [4:0]  amt_out;

    int checks = 0;
    int errors = 0;
    logic [4:0] m_amt = '0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] out;
        logic [4:0]  amt;
        string       req;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    shamt_barrel u_shamt_barrel (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .mode(mode),
        .amt_op(amt_op), .data_out(data_out), .amt_out(amt_out)
    );

    function automatic logic [31:0] model(input logic [31:0] d, input logic [1:0] m,
                                          input logic [4:0] s);
        logic [31:0] r;
        r = '0;
        case (m)
            2'd0: r = d;
            2'd1: for (int i = 0; i < 32; i++) r[i] = (i + s < 32) ? d[i + s] : 1'b0;
            2'd2: for (int i = 0; i < 32; i++) r[i] = (s != 0 && i >= 32 - s) ? d[i - (32 - s)] : 1'b0;
            default: for (int i = 0; i < 32; i++) r[i] = d[(i + s) % 32];
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] d, input logic [1:0] m, input logic [1:0] op,
                        input string req);
        exp_t e;
        logic [31:0] o;
        @(negedge clk);
        data_in = d; mode = m; amt_op = op;
        o = model(d, m, m_amt);
        e.out = o; e.amt = m_amt; e.req = req;
        sb_q.push_back(e);
        case (op)
            2'd1: m_amt = 5'(32 - int'(m_amt));
            2'd2: m_amt = {o[5:3], o[1:0]};
            default: ;
        endcase
    endtask

    // monitor: compares after the driver has set inputs for the cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.req, " data"}, data_out, e.out);
                check({e.req, "/R9 amt"}, {27'd0, amt_out}, {27'd0, e.amt});
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h8000_0001; pats[1] = 32'hDEAD_BEEF;
        pats[2] = 32'hFFFF_FFFF; pats[3] = 32'h1234_5678;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset amt", {27'd0, amt_out}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // amount 0 corner cases
        step(32'hCAFE_F00D, 2'd2, 2'd0, "R4 zero amt");
        step(32'hCAFE_F00D, 2'd3, 2'd0, "R5 zero amt");
        step(32'hA5A5_0F0F, 2'd1, 2'd1, "R7 negate zero");
        step(32'hA5A5_0F0F, 2'd0, 2'd0, "R7 after negate zero");
        for (int k = 0; k < 32; k++) begin
            logic [31:0] ld;
            ld = 32'h5A00_0000 | {26'd0, 5'(k) >> 2, 1'b0, 2'(k)};
            step(ld, 2'd0, 2'd2, "R8 load pass");
            for (int m = 0; m < 4; m++)
                for (int p = 0; p < 4; p++)
                    step(pats[p], 2'(m), (p == 1) ? 2'd3 : 2'd0,
                         (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5");
            step(32'h0F0F_0F0F, 2'd3, 2'd0, "R6 keep");
            step(32'h0F0F_0F0F, 2'd1, 2'd1, "R7 negate");
            step(32'hF0F0_1234, 2'd2, 2'd1, "R7 negate back");
            step(32'hF0F0_1234, 2'd1, 2'd2, "R8 load shifted");
            step(32'h1357_9BDF, 2'd3, 2'd3, "R6 keep alt");
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule